// File: doc/BRIEF.md
# Flash Completion Poll Engine

This block sits on the host side of a parallel flash device and decides whether a program or erase operation, already launched by other logic, has finished. A single start pulse hands it the location to watch and the byte that the operation should leave behind (all ones for an erase). The engine then reads that location repeatedly through a simple request/response read port. Each returned byte is judged on two status bits: a completion bit that shows the true value of the expected byte once the operation is over, and a time-limit bit that the flash raises when its internal algorithm has run too long.

A raised time-limit bit is not taken as a failure on its own. The completion bit can flip in the same moment the time-limit bit rises, so the engine reads the location one more time and lets that read decide the outcome. When the completion bit is seen to match, the other bits of the byte may not yet be settled. The engine therefore performs one more read and reports that byte as the final data. A poll budget ends the operation with a failure if the flash never reports either completion or time-limit. The result is shown as registered pass and fail levels and a one-cycle done pulse.

Top module: `flash_poll_checker`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. It captures `addr_i` and `expect_i` and raises `busy_o` in the next cycle. A start pulse given while busy has no effect on the address read, the read count or the result.
- R2: Every read is a one-cycle pulse on `rd_req_o` with `rd_addr_o` equal to the captured address. No new request is raised while an earlier request still waits for `rd_valid_i`.
- R3: A poll byte whose completion bit (bit 7) equals bit 7 of the expected byte counts as a match, and the operation moves on to pass.
- R4: A poll byte with a completion-bit mismatch and the time-limit bit (bit 5) at 0 leads to another poll read of the same address.
- R5: A poll byte with a completion-bit mismatch and bit 5 at 1 leads to exactly one recheck read. A bit 7 match on that recheck gives pass. A mismatch gives fail, whatever bit 5 then holds.
- R6: With `FINAL_READ` = 1, a match is followed by one more read, and the byte returned by that read appears on `final_data_o`.
- R7: If `MAX_POLLS` poll reads (rechecks and final reads not counted) all return busy bytes (bit 7 mismatch, bit 5 at 0), the operation ends in fail.
- R8: `done_o` is high for exactly one cycle, in the cycle after the response that ends the operation. `pass_o` and `fail_o` are never high together and hold their value until the next accepted start. At done, `final_data_o` holds the last byte read.
- R9: After reset, `busy_o`, `rd_req_o`, `pass_o`, `fail_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (pulse) |
| addr_i | input | ADDR_W | Location to poll |
| expect_i | input | DATA_W | Byte the operation should leave behind |
| busy_o | output | 1 | An operation is in progress |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read response byte |
| pass_o | output | 1 | Operation completed successfully (held) |
| fail_o | output | 1 | Operation failed (held) |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| final_data_o | output | DATA_W | Last byte read |

## Verification
The bench builds the engine with `MAX_POLLS` = 6 and `FINAL_READ` = 1. The small budget lets an operation run out of polls within a few dozen cycles, and it makes it cheap to raise the time-limit bit on the very last allowed poll, where the recheck must still happen. The final-read variant is chosen so that the byte on `final_data_o` can differ from the matching poll byte, which shows that the extra read really takes place. Both polarities of expected bit 7 are covered, for program-style and erase-style expected bytes.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   // outcome of judging one returned status byte
   typedef enum logic [1:0] {
      VERD_MATCH = 2'd0,
      VERD_TMO   = 2'd1,
      VERD_BUSY  = 2'd2
   } verdict_t;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_POLL_REQ  = 3'd1,
      ST_POLL_WAIT = 3'd2,
      ST_RCHK_REQ  = 3'd3,
      ST_RCHK_WAIT = 3'd4,
      ST_FIN_REQ   = 3'd5,
      ST_FIN_WAIT  = 3'd6
   } state_t;

endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
   import fpc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DONE_BIT = 7,
   parameter int TMO_BIT  = 5
) (
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] expect_i,
   output verdict_t          verdict_o
);

   logic done_eq;
   logic tmo_set;

   assign done_eq = (status_i[DONE_BIT] == expect_i[DONE_BIT]);
   assign tmo_set = status_i[TMO_BIT];

   always_comb begin
      if (done_eq)       verdict_o = VERD_MATCH;
      else if (tmo_set)  verdict_o = VERD_TMO;
      else               verdict_o = VERD_BUSY;
   end

endmodule

// File: rtl/fpc_budget.sv
module fpc_budget #(
   parameter int MAX_POLLS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic inc_i,
   output logic last_o
);

   localparam int CNT_W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear_i)  cnt_q <= '0;
      else if (inc_i && cnt_q != LAST_VAL) cnt_q <= cnt_q + 1'b1;
   end

   // high while the poll now awaited is the last one allowed
   assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
   import fpc_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 8,
   parameter int DONE_BIT   = 7,
   parameter int TMO_BIT    = 5,
   parameter int MAX_POLLS  = 4096,
   parameter int FINAL_READ = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] expect_i,
   output logic              busy_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              pass_o,
   output logic              fail_o,
   output logic              done_o,
   output logic [DATA_W-1:0] final_data_o
);

   localparam bit HAS_BUDGET = (MAX_POLLS > 0);
   localparam bit DO_FINAL   = (FINAL_READ != 0);

   if (DATA_W < 8) begin : g_chk_width
      $error("flash_poll_checker: DATA_W must be at least 8");
   end
   if (DONE_BIT >= DATA_W || TMO_BIT >= DATA_W || DONE_BIT == TMO_BIT) begin : g_chk_bits
      $error("flash_poll_checker: status bit positions invalid");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("flash_poll_checker: ADDR_W must be positive");
   end
   if (FINAL_READ != 0 && FINAL_READ != 1) begin : g_chk_final
      $error("flash_poll_checker: FINAL_READ must be 0 or 1");
   end

   state_t            state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] exp_q;
   logic [DATA_W-1:0] last_q;
   logic              pass_q;
   logic              fail_q;
   logic              done_q;
   verdict_t          verdict;
   logic              budget_last;
   logic              accept;
   logic              poll_resp;

   assign accept    = (state_q == ST_IDLE) && start_i;
   assign poll_resp = (state_q == ST_POLL_WAIT) && rd_valid_i;

   fpc_classify #(
      .DATA_W   (DATA_W),
      .DONE_BIT (DONE_BIT),
      .TMO_BIT  (TMO_BIT)
   ) u_classify (
      .status_i  (rd_data_i),
      .expect_i  (exp_q),
      .verdict_o (verdict)
   );

   if (HAS_BUDGET) begin : g_budget
      fpc_budget #(
         .MAX_POLLS (MAX_POLLS)
      ) u_budget (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (accept),
         .inc_i   (poll_resp),
         .last_o  (budget_last)
      );
   end else begin : g_no_budget
      assign budget_last = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         exp_q   <= '0;
         last_q  <= '0;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  addr_q  <= addr_i;
                  exp_q   <= expect_i;
                  pass_q  <= 1'b0;
                  fail_q  <= 1'b0;
                  state_q <= ST_POLL_REQ;
               end
            end
            ST_POLL_REQ: state_q <= ST_POLL_WAIT;
            ST_POLL_WAIT: begin
               if (rd_valid_i) begin
                  last_q <= rd_data_i;
                  unique case (verdict)
                     VERD_MATCH: begin
                        if (DO_FINAL) begin
                           state_q <= ST_FIN_REQ;
                        end else begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                           pass_q  <= 1'b1;
                        end
                     end
                     VERD_TMO: state_q <= ST_RCHK_REQ;
                     default: begin
                        if (budget_last) begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                           fail_q  <= 1'b1;
                        end else begin
                           state_q <= ST_POLL_REQ;
                        end
                     end
                  endcase
               end
            end
            ST_RCHK_REQ: state_q <= ST_RCHK_WAIT;
            ST_RCHK_WAIT: begin
               if (rd_valid_i) begin
                  last_q <= rd_data_i;
                  if (verdict == VERD_MATCH && DO_FINAL) begin
                     state_q <= ST_FIN_REQ;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     pass_q  <= (verdict == VERD_MATCH);
                     fail_q  <= (verdict != VERD_MATCH);
                  end
               end
            end
            ST_FIN_REQ: state_q <= ST_FIN_WAIT;
            ST_FIN_WAIT: begin
               if (rd_valid_i) begin
                  last_q  <= rd_data_i;
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  pass_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o       = (state_q != ST_IDLE);
   assign rd_req_o     = (state_q == ST_POLL_REQ) || (state_q == ST_RCHK_REQ)
                         || (state_q == ST_FIN_REQ);
   assign rd_addr_o    = addr_q;
   assign pass_o       = pass_q;
   assign fail_o       = fail_q;
   assign done_o       = done_q;
   assign final_data_o = last_q;

endmodule

// File: rtl/fpc_sva.sv
module fpc_sva #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i,
   input logic              pass_o,
   input logic              fail_o,
   input logic              done_o
);

   logic waiting_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          waiting_q <= 1'b0;
      else if (rd_req_o)   waiting_q <= 1'b1;
      else if (rd_valid_i) waiting_q <= 1'b0;
   end

   // R2: request lasts one cycle
   assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

   // R2: no request while one is outstanding
   assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !waiting_q);

   // R1: address held for the whole operation
   assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (!busy_o || $stable(rd_addr_o)));

   // R8: done is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: pass and fail exclusive
   assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   // R8: done follows a read response
   assert_done_after_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(rd_valid_i));

endmodule

bind flash_poll_checker fpc_sva #(
   .ADDR_W (ADDR_W)
) u_fpc_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .rd_req_o   (rd_req_o),
   .rd_addr_o  (rd_addr_o),
   .rd_valid_i (rd_valid_i),
   .pass_o     (pass_o),
   .fail_o     (fail_o),
   .done_o     (done_o)
);

// File: tb/flash_poll_checker_tb_top.sv
module flash_poll_checker_tb_top;

   localparam int ADDR_W = 20;
   localparam int DATA_W = 8;
   localparam int MAXP   = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [DATA_W-1:0] expect_i = '0;
   logic              busy_o, rd_req_o, pass_o, fail_o, done_o;
   logic [ADDR_W-1:0] rd_addr_o;
   logic              rd_valid_i = 1'b0;
   logic [DATA_W-1:0] rd_data_i = '0;
   logic [DATA_W-1:0] final_data_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0]        script[$];
   logic              pending = 1'b0;
   logic              prev_done = 1'b0;
   int                rd_seen = 0;
   logic [ADDR_W-1:0] exp_addr = '0;
   logic              mon_on = 1'b0;

   always #2 clk = ~clk;

   flash_poll_checker #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .DONE_BIT   (7),
      .TMO_BIT    (5),
      .MAX_POLLS  (MAXP),
      .FINAL_READ (1)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .addr_i       (addr_i),
      .expect_i     (expect_i),
      .busy_o       (busy_o),
      .rd_req_o     (rd_req_o),
      .rd_addr_o    (rd_addr_o),
      .rd_valid_i   (rd_valid_i),
      .rd_data_i    (rd_data_i),
      .pass_o       (pass_o),
      .fail_o       (fail_o),
      .done_o       (done_o),
      .final_data_o (final_data_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // flash responder and per-clock reference comparison
   always @(negedge clk) begin
      cycles++;
      rd_valid_i = 1'b0;
      if (pending) begin
         rd_valid_i = 1'b1;
         rd_data_i  = (script.size() > 0) ? script.pop_front() : 8'h00;
         pending    = 1'b0;
      end
      if (mon_on) begin
         if (rd_req_o) begin
            rd_seen++;
            check(rd_addr_o == exp_addr, "R2", "read address", int'(rd_addr_o), int'(exp_addr));
            check(!pending && !rd_valid_i, "R2", "request while outstanding", 1, 0);
            pending = 1'b1;
         end
         if (done_o)
            check(!prev_done, "R8", "done longer than one cycle", 1, 0);
         if (pass_o && fail_o)
            check(1'b0, "R8", "pass and fail together", 1, 0);
      end
      prev_done = done_o;
   end

   // outcome expected from the requirements for the queued bytes
   task automatic predict(input logic [7:0] e, output bit ok, output int reads,
                          output logic [7:0] last);
      int idx = 0;
      int polls = 0;
      bit matched = 0;
      bit ended = 0;
      logic [7:0] b;
      while (!ended) begin
         b = script[idx]; idx++; polls++;
         if (b[7] == e[7]) begin
            matched = 1; ended = 1;
         end else if (b[5]) begin
            b = script[idx]; idx++;
            matched = (b[7] == e[7]); ended = 1;
         end else if (polls == MAXP) begin
            ended = 1;
         end
      end
      if (matched) idx++;
      ok = matched;
      reads = idx;
      last = script[idx-1];
   endtask

   task automatic run_op(input logic [ADDR_W-1:0] a, input logic [7:0] e,
                         input bit inject, input string req);
      bit ok;
      int reads;
      logic [7:0] last;
      int n = 0;
      predict(e, ok, reads, last);
      @(negedge clk);
      rd_seen  = 0;
      exp_addr = a;
      start_i  = 1'b1;
      addr_i   = a;
      expect_i = e;
      @(negedge clk);
      start_i  = 1'b0;
      check(busy_o == 1'b1, "R1", "busy after start", int'(busy_o), 1);
      if (inject) begin
         @(negedge clk);
         start_i  = 1'b1;
         addr_i   = a ^ 20'h00F0F;
         expect_i = ~e;
         @(negedge clk);
         start_i  = 1'b0;
      end
      while (!done_o && n < 400) begin
         @(negedge clk);
         n++;
      end
      check(done_o == 1'b1, req, "done reached", int'(done_o), 1);
      check(pass_o == ok, req, "pass", int'(pass_o), int'(ok));
      check(fail_o == !ok, req, "fail", int'(fail_o), int'(!ok));
      check(final_data_o == last, "R8", "final data", int'(final_data_o), int'(last));
      check(rd_seen == reads, req, "read count", rd_seen, reads);
      @(negedge clk);
      check(done_o == 1'b0, "R8", "done cleared", int'(done_o), 0);
      check(pass_o == ok, "R8", "result held", int'(pass_o), int'(ok));
      check(busy_o == 1'b0, "R8", "idle after done", int'(busy_o), 0);
      script.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy_o && !rd_req_o && !pass_o && !fail_o && !done_o, "R9", "reset outputs",
            {busy_o, rd_req_o, pass_o, fail_o, done_o}, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o, "R9", "idle after reset release", int'(busy_o), 0);

      // R3 R4 R6: two busy polls, match, final byte differs
      script = '{8'h00, 8'h04, 8'h80, 8'hA5};
      run_op(20'h12345, 8'hA5, 0, "R4");

      // R5 R6: erase, time-limit then recheck matches
      script = '{8'h00, 8'h20, 8'h80, 8'hFF};
      run_op(20'h7FFFF, 8'hFF, 0, "R5");

      // R5: time-limit then recheck mismatch -> fail (bit5 clear on recheck)
      script = '{8'h20, 8'h00};
      run_op(20'h00010, 8'hFF, 0, "R5");

      // R7: budget exhausted
      script = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      run_op(20'h00ABC, 8'h80, 0, "R7");

      // R7 R5: time-limit on the last allowed poll still rechecks
      script = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h80, 8'h80};
      run_op(20'h55555, 8'h80, 0, "R7");

      // R3 R6: expected bit7 = 0, final read byte is reported
      script = '{8'h80, 8'h0C, 8'h33};
      run_op(20'h0F0F0, 8'h00, 0, "R3");

      // R1: start while busy is ignored
      script = '{8'h00, 8'h00, 8'h00, 8'hA0, 8'h9C};
      run_op(20'h31415, 8'h9C, 1, "R1");

      // R3: immediate match on first poll
      script = '{8'h7F, 8'h11};
      run_op(20'h00001, 8'h01, 0, "R3");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule